// File: doc/BRIEF.md
# Dithered 16-bit DAC Code Modulator

This block drives an 8-bit DAC code so that its time average carries a 16-bit sample. The upper byte of the sample is the base code. The lower byte is a fraction: in every 256-clock frame, the code is raised by one LSB on that many clocks. A phase accumulator chooses those clocks, so the raised clocks are spread evenly across the frame rather than bunched at one end. The average over a frame grows by one part in 256 of an LSB for each step of the lower byte, and it never goes down when the sample goes up.

The host writes samples into a holding register at any time. The block moves the held sample into use only at a frame boundary. In the first clock of the frame that uses the new sample, it raises a one-clock flag, which tells the host the holding register is free for the next sample. If no new sample has been written, the current sample is repeated frame after frame and no flag is raised.

Top module: `dither_dac`

## Requirements
- R1: While reset is held and in the first clock after it is released, the code output is 0 and the take flag is low.
- R2: Over any full 256-clock frame, the code outputs add up to 256*U + L. Here U is the upper byte and L is the lower byte of the sample in use. When U is 255, the sum is 255*256 instead.
- R3: In frame clock j (0 to 255), the code is U+1 when floor((j+1)*L/256) > floor(j*L/256), and U otherwise.
- R4: When U is 255, the code is 255 on every clock, whatever L is.
- R5: A sample written on any frame clock other than the last one does not change the output for the rest of that frame. It comes into use at the next frame clock 0.
- R6: The take flag is high for exactly one clock, which is frame clock 0. This happens only when a new sample came into use at that boundary.
- R7: A sample written on the last frame clock (clock 255) is used from the very next clock, and the take flag is raised there.
- R8: When several samples are written within one frame, only the last one written comes into use.
- R9: If no sample is written during a frame, the next frame repeats the same sample and the take flag stays low.
- R10: A frame is exactly 256 clocks, so takes always fall a whole number of frames apart, counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Sample: upper byte is the base code, lower byte is the fraction |
| code_out | output | 8 | DAC code for this clock |
| take | output | 1 | One-clock pulse when a held sample comes into use |

## Verification
Two things can happen in the same cycle: a host write and the frame boundary that transfers the holding register. The bench provokes this by writing on frame clock 255. Sometimes that write stands alone, and sometimes it overwrites a sample already held from earlier in the frame. It then checks that the newest value drives the code from clock 0 and that the take flag fires. The bench compares every clock against an arithmetic model built from floor((j+1)*L/256), and it checks each frame's code sum. The sweep covers every fraction value, including fractions paired with a saturated upper byte.

// File: rtl/dither_dac.sv
module dither_dac #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic [CODE_W-1:0]   code_out,
  output logic                take
);
  localparam int FRAC_W = SAMPLE_W - CODE_W;
  localparam logic [FRAC_W-1:0] LAST = {FRAC_W{1'b1}};
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};

  logic [FRAC_W-1:0]   frame_pos;
  logic [FRAC_W-1:0]   acc;
  logic [SAMPLE_W-1:0] act;
  logic [SAMPLE_W-1:0] pend;
  logic                pend_vld;

  wire                boundary = (frame_pos == LAST);
  wire [CODE_W-1:0]   base     = act[SAMPLE_W-1:FRAC_W];
  wire [FRAC_W-1:0]   frac     = act[FRAC_W-1:0];
  wire [FRAC_W:0]     sum      = {1'b0, acc} + {1'b0, frac};
  wire                bump     = sum[FRAC_W];
  wire                load     = boundary && (wr_en || pend_vld);

  assign code_out = (bump && base != TOP) ? base + 1'b1 : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_pos <= '0;
      acc       <= '0;
      act       <= '0;
      pend      <= '0;
      pend_vld  <= 1'b0;
      take      <= 1'b0;
    end else begin
      frame_pos <= frame_pos + 1'b1;
      acc       <= boundary ? '0 : sum[FRAC_W-1:0];
      take      <= load;
      if (load)
        act <= wr_en ? wr_data : pend;
      if (boundary) begin
        pend_vld <= 1'b0;
      end else if (wr_en) begin
        pend     <= wr_data;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

module dither_dac_checks #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       take,
  input logic                       pend_vld,
  input logic [CODE_W-1:0]          code_out,
  input logic [SAMPLE_W-CODE_W-1:0] frame_pos,
  input logic [SAMPLE_W-1:0]        act
);
  localparam int FRAC_W = SAMPLE_W - CODE_W;
  localparam logic [FRAC_W-1:0] LAST = {FRAC_W{1'b1}};
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};

  wire [CODE_W-1:0] base = act[SAMPLE_W-1:FRAC_W];

  a_r6_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  a_r6_take_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> frame_pos == '0);
  a_r9_take_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(pend_vld || wr_en));
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos == LAST |=> frame_pos == '0);
  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos != LAST |=> frame_pos == FRAC_W'($past(frame_pos) + 1'b1));
  a_r5_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos != '0 |-> $stable(act));
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    base == TOP |-> code_out == TOP);
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    base != TOP |-> (code_out == base || code_out == CODE_W'(base + 1'b1)));
endmodule

bind dither_dac dither_dac_checks #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .take(take), .pend_vld(pend_vld),
  .code_out(code_out), .frame_pos(frame_pos), .act(act)
);

// File: tb/dither_dac_test.sv
`timescale 1ns/1ps
module dither_dac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  code_out;
  logic        take;

  int compared = 0;
  int mismatched = 0;

  int    j = 0;
  int    m_act = 0;
  int    m_pend = 0;
  bit    m_pv = 1'b0;
  bit    m_take = 1'b0;
  int    fsum = 0;
  string tag = "";

  always #2.5 clk = ~clk;

  dither_dac uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                  .code_out(code_out), .take(take));

  function automatic int exp_code(int pos, int s);
    int u = s >> 8;
    int l = s & 255;
    if (u == 255) return 255;
    return u + ((pos + 1) * l) / 256 - (pos * l) / 256;
  endfunction

  task automatic chk(string req, int act_v, int exp_v);
    compared++;
    if (act_v != exp_v) begin
      mismatched++;
      $display("FAIL %s at pos %0d: got %0d expected %0d", req, j, act_v, exp_v);
    end
  endtask

  task automatic observe();
    string t;
    int u;
    t = (tag != "") ? tag : (((m_act >> 8) == 255) ? "R4" : "R3");
    chk(t, code_out, exp_code(j, m_act));
    chk("R6", take, m_take);
    if (take) chk("R10", j, 0);
    fsum += code_out;
    if (j == 255) begin
      u = m_act >> 8;
      chk("R2", fsum, (u == 255) ? 255 * 256 : u * 256 + (m_act & 255));
      fsum = 0;
    end
  endtask

  task automatic step(bit w, int d);
    wr_en = w;
    wr_data = 16'(d);
    @(posedge clk);
    if (j == 255) begin
      m_take = w || m_pv;
      if (w) m_act = d;
      else if (m_pv) m_act = m_pend;
      m_pv = 1'b0;
    end else begin
      m_take = 1'b0;
      if (w) begin m_pend = d; m_pv = 1'b1; end
    end
    j = (j + 1) & 255;
    @(negedge clk);
    wr_en = 1'b0;
    observe();
  endtask

  task automatic idle_to(int pos);
    while (j != pos) step(1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", code_out, 0);
    chk("R1", take, 0);
    rst_n = 1'b1;
    #0.1;
    chk("R1", code_out, 0);
    chk("R1", take, 0);
    observe();

    for (int f = 0; f < 256; f++) begin
      int u = (f * 37 + 11) % 255;
      if (f % 64 == 63) u = 255;
      idle_to(100);
      tag = "R5";
      step(1'b1, (u << 8) | f);
      idle_to(255);
      tag = "";
    end
    idle_to(0);

    idle_to(40);
    tag = "R8";
    step(1'b1, 16'h1234);
    idle_to(200);
    step(1'b1, 16'h7FC1);
    idle_to(255);
    tag = "";
    idle_to(128);

    idle_to(255);
    tag = "R7";
    step(1'b1, 16'hA055);
    idle_to(255);

    idle_to(10);
    step(1'b1, 16'h0101);
    idle_to(255);
    step(1'b1, 16'hFE80);
    tag = "";
    idle_to(255);

    tag = "R9";
    for (int n = 0; n < 2 * 256; n++) step(1'b0, 0);
    tag = "";

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule